// File: doc/BRIEF.md
# Video Encoder Serial Control Register File

This block is the two-wire serial control port of a video encoder. An external controller writes settings for output format, luma and chroma processing, power-down requests, audio clock choice and closed-caption data. It can also read them back. Seven 8-bit registers sit behind a one-byte register index. Every register field is decoded into a dedicated output, so the encoder datapath, the DAC power logic and the clock generator take their settings straight from wires.

SCL and SDA are sampled on the system clock and edge-detected. The block pulls SDA low through an output enable and never drives it high. A write transaction carries the device address with a write flag, then a register index, then one or more data bytes. Each data byte advances the index. A read is a write of the index, a repeated START with the read flag, and then bytes shifted out MSB first. The block stops sending when the controller does not acknowledge a byte.

Top module: `vidctl_i2c_regs`

## Requirements
- R1: The block acknowledges only the 7-bit device address 0x65, or 0x64 when parameter ALT_ADDR is 1. For any other address it never drives SDA for the rest of that transaction, and no register changes.
- R2: An address byte in the frame (address bits 7:1, R/W bit 0 with 0 = write) is followed by an index byte and data bytes, all MSB first. The slave acknowledges each byte by holding SDA low during the ninth SCL pulse.
- R3: Seven registers live at indices 0x00 to 0x06, and all reset to 0x00. At reset every decoded output is 0 and SDA is released.
- R4: Successive data bytes in one write go to successive indices.
- R5: A data byte for an index above 0x06 is acknowledged but changes nothing. A read at such an index returns 0x00.
- R6: After a repeated START with R/W = 1, the addressed register is shifted out MSB first. Each controller acknowledge advances the index, and a missing acknowledge makes the slave release SDA.
- R7: START and STOP are recognised as SDA falling and rising while SCL is high. A START at any point restarts the address phase, and a STOP ends the transaction.
- R8: Register 0x00 decodes as follows: bits 7:6 chroma bandwidth, bits 5:4 component mode (writing 0x30 gives 11, which is RGB), bit 3 HSYNC alignment on luma, bit 2 subcarrier free-run, bit 1 alternate colour standard, bit 0 625-line timing.
- R9: Register 0x01 decodes as follows: bit 7 VBI pass-through, bits 6:5 caption field enable, bit 4 luma delay, bits 3:2 brightness, bits 1:0 contrast.
- R10: Register 0x02 decodes as follows: bit 7 monochrome, bit 6 composite DAC power-down, bit 5 S-video DAC power-down, bits 1:0 audio clock select. Bit 4 drives both general-purpose output enables, and 0 means high impedance. Bit 3 sets gp_out[1] and bit 2 sets gp_out[0].
- R11: ext_cc is {reg 0x03, reg 0x04} and cc_word is {reg 0x05, reg 0x06}, with the high byte first.
- R12: A transaction that ends before a complete data byte leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 |
| chroma_bw | output | 2 | Chroma filter bandwidth select |
| comp_mode | output | 2 | Component output mode |
| hs_on_luma | output | 1 | Input HSYNC edge aligned to luma sample |
| subc_free | output | 1 | Subcarrier free-running |
| alt_std | output | 1 | Alternate colour standard |
| fmt_625 | output | 1 | 625-line master timing |
| vbi_pass | output | 1 | Vertical interval not blanked |
| cc_field_en | output | 2 | Caption field enable |
| luma_delay | output | 1 | Luma delay on |
| bright_sel | output | 2 | Brightness setting |
| contrast_sel | output | 2 | Contrast setting |
| mono | output | 1 | Monochrome output |
| pd_composite | output | 1 | Composite DAC power-down request |
| pd_svideo | output | 1 | S-video DAC power-down request |
| gp_oe | output | 2 | General-purpose pin output enables |
| gp_out | output | 2 | General-purpose pin values |
| aclk_sel | output | 2 | Audio clock select |
| ext_cc | output | 16 | Extended caption word |
| cc_word | output | 16 | Caption word |

## Verification
Committing a data byte and advancing the register index happen in the same system clock cycle. So the last legal register and the first discarded index can meet inside one burst. The bench provokes this with a two-byte write starting at index 0x06. It judges the result by reading 0x06 back through a repeated START, by reading 0x00 at index 0x07, and by checking that no decoded output tied to the other registers moved.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;
  localparam int NREG = 7;
  localparam int DW   = 8;
  localparam int AW   = 8;

  localparam int IX_VIDEO = 0;
  localparam int IX_LUMA  = 1;
  localparam int IX_SYS   = 2;
  localparam int IX_XCCH  = 3;
  localparam int IX_XCCL  = 4;
  localparam int IX_CCH   = 5;
  localparam int IX_CCL   = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_IDX, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK, ST_RLOAD
  } ser_st_t;

  function automatic logic [6:0] dev_addr(input logic alt);
    return alt ? 7'h64 : 7'h65;
  endfunction

  function automatic logic in_range(input logic [AW-1:0] a);
    return a < AW'(NREG);
  endfunction

  function automatic logic [AW-1:0] next_index(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction
endpackage

// File: rtl/vidctl_line_sync.sv
module vidctl_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_m, sda_m;
  logic       scl_p, sda_p;
  logic       scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_p <= scl_m[1];
      sda_p <= sda_m[1];
    end
  end

  assign scl_s     = scl_m[1];
  assign sda_s     = sda_m[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/vidctl_i2c_fsm.sv
module vidctl_i2c_fsm
  import vidctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h65
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sda_oe
);
  ser_st_t       st, nxt;
  logic [2:0]    cnt;
  logic [DW-1:0] rx, tx;
  logic [DW-1:0] rx_byte;
  logic [AW-1:0] ptr;
  logic          ack_on;
  logic          byte_done;

  assign rx_byte   = {rx[DW-2:0], sda_s};
  assign byte_done = scl_rise && (cnt == 3'd7);
  assign rd_addr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      nxt     <= ST_IDLE;
      cnt     <= '0;
      rx      <= '0;
      tx      <= '0;
      ptr     <= '0;
      ack_on  <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= ST_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_DEV, ST_IDX, ST_WDATA: begin
            if (scl_rise) begin
              rx  <= rx_byte;
              cnt <= cnt + 3'd1;
            end
            if (byte_done) begin
              ack_on <= 1'b0;
              if (st == ST_DEV) begin
                if (rx_byte[7:1] == DEV_ADDR) begin
                  st  <= ST_ACK;
                  nxt <= rx_byte[0] ? ST_RDATA : ST_IDX;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_IDX) begin
                ptr <= rx_byte;
                st  <= ST_ACK;
                nxt <= ST_WDATA;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= rx_byte;
                ptr     <= next_index(ptr);
                st      <= ST_ACK;
                nxt     <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!ack_on) begin
                sda_oe <= 1'b1;
                ack_on <= 1'b1;
              end else begin
                ack_on <= 1'b0;
                cnt    <= '0;
                st     <= nxt;
                if (nxt == ST_RDATA) begin
                  tx     <= rd_data;
                  sda_oe <= ~rd_data[DW-1];
                end else begin
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                tx     <= {tx[DW-2:0], 1'b0};
                sda_oe <= ~tx[DW-2];
                cnt    <= cnt + 3'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_s) begin
                st <= ST_IDLE;
              end else begin
                ptr <= next_index(ptr);
                st  <= ST_RLOAD;
              end
            end
          end
          ST_RLOAD: begin
            if (scl_fall) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              cnt    <= '0;
              st     <= ST_RDATA;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R7
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_DEV && cnt == 3'd0));
  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !sda_oe));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  // R2
  drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> (st == ST_ACK || st == ST_RDATA));
  // R4
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == next_index(wr_addr)));
endmodule

// File: rtl/vidctl_reg_bank.sv
module vidctl_reg_bank
  import vidctl_pkg::*;
#(
  parameter int N = NREG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [N*DW-1:0] reg_flat
);
  localparam int IW = $clog2(N);

  logic [DW-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                regs[i] <= '0;
      else if (wr_en && wr_addr == AW'(i))       regs[i] <= wr_data;
    end
    assign reg_flat[i*DW +: DW] = regs[i];
  end

  assign rd_data = in_range(rd_addr) ? regs[rd_addr[IW-1:0]] : '0;

  // R12
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_flat));
  // R5
  discard_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range(wr_addr)) |=> $stable(reg_flat));
endmodule

// File: rtl/vidctl_decode.sv
module vidctl_decode
  import vidctl_pkg::*;
(
  input  logic [NREG*DW-1:0] reg_flat,
  output logic [1:0]  chroma_bw,
  output logic [1:0]  comp_mode,
  output logic        hs_on_luma,
  output logic        subc_free,
  output logic        alt_std,
  output logic        fmt_625,
  output logic        vbi_pass,
  output logic [1:0]  cc_field_en,
  output logic        luma_delay,
  output logic [1:0]  bright_sel,
  output logic [1:0]  contrast_sel,
  output logic        mono,
  output logic        pd_composite,
  output logic        pd_svideo,
  output logic [1:0]  gp_oe,
  output logic [1:0]  gp_out,
  output logic [1:0]  aclk_sel,
  output logic [15:0] ext_cc,
  output logic [15:0] cc_word
);
  logic [DW-1:0] r_vid, r_luma, r_sys;

  assign r_vid  = reg_flat[IX_VIDEO*DW +: DW];
  assign r_luma = reg_flat[IX_LUMA*DW  +: DW];
  assign r_sys  = reg_flat[IX_SYS*DW   +: DW];

  assign chroma_bw    = r_vid[7:6];
  assign comp_mode    = r_vid[5:4];
  assign hs_on_luma   = r_vid[3];
  assign subc_free    = r_vid[2];
  assign alt_std      = r_vid[1];
  assign fmt_625      = r_vid[0];

  assign vbi_pass     = r_luma[7];
  assign cc_field_en  = r_luma[6:5];
  assign luma_delay   = r_luma[4];
  assign bright_sel   = r_luma[3:2];
  assign contrast_sel = r_luma[1:0];

  assign mono         = r_sys[7];
  assign pd_composite = r_sys[6];
  assign pd_svideo    = r_sys[5];
  assign gp_oe        = {2{r_sys[4]}};
  assign gp_out       = r_sys[3:2];
  assign aclk_sel     = r_sys[1:0];

  assign ext_cc  = {reg_flat[IX_XCCH*DW +: DW], reg_flat[IX_XCCL*DW +: DW]};
  assign cc_word = {reg_flat[IX_CCH*DW  +: DW], reg_flat[IX_CCL*DW  +: DW]};
endmodule

// File: rtl/vidctl_i2c_regs.sv
module vidctl_i2c_regs
  import vidctl_pkg::*;
#(
  parameter bit ALT_ADDR = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [1:0]  chroma_bw,
  output logic [1:0]  comp_mode,
  output logic        hs_on_luma,
  output logic        subc_free,
  output logic        alt_std,
  output logic        fmt_625,
  output logic        vbi_pass,
  output logic [1:0]  cc_field_en,
  output logic        luma_delay,
  output logic [1:0]  bright_sel,
  output logic [1:0]  contrast_sel,
  output logic        mono,
  output logic        pd_composite,
  output logic        pd_svideo,
  output logic [1:0]  gp_oe,
  output logic [1:0]  gp_out,
  output logic [1:0]  aclk_sel,
  output logic [15:0] ext_cc,
  output logic [15:0] cc_word
);
  localparam logic [6:0] DEV = dev_addr(ALT_ADDR);

  logic               sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic               wr_en;
  logic [AW-1:0]      wr_addr, rd_addr;
  logic [DW-1:0]      wr_data, rd_data;
  logic [NREG*DW-1:0] reg_flat;

  vidctl_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  vidctl_i2c_fsm #(.DEV_ADDR(DEV)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  vidctl_reg_bank #(.N(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .reg_flat(reg_flat)
  );

  vidctl_decode u_dec (
    .reg_flat(reg_flat),
    .chroma_bw(chroma_bw), .comp_mode(comp_mode), .hs_on_luma(hs_on_luma),
    .subc_free(subc_free), .alt_std(alt_std), .fmt_625(fmt_625),
    .vbi_pass(vbi_pass), .cc_field_en(cc_field_en), .luma_delay(luma_delay),
    .bright_sel(bright_sel), .contrast_sel(contrast_sel), .mono(mono),
    .pd_composite(pd_composite), .pd_svideo(pd_svideo), .gp_oe(gp_oe),
    .gp_out(gp_out), .aclk_sel(aclk_sel), .ext_cc(ext_cc), .cc_word(cc_word)
  );
endmodule

// File: tb/sim_vidctl_i2c_regs.sv
module sim_vidctl_i2c_regs;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  logic [1:0]  chroma_bw, comp_mode, cc_field_en, bright_sel, contrast_sel;
  logic [1:0]  gp_oe, gp_out, aclk_sel;
  logic        hs_on_luma, subc_free, alt_std, fmt_625, vbi_pass, luma_delay;
  logic        mono, pd_composite, pd_svideo;
  logic [15:0] ext_cc, cc_word;

  vidctl_i2c_regs u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .chroma_bw(chroma_bw), .comp_mode(comp_mode), .hs_on_luma(hs_on_luma),
    .subc_free(subc_free), .alt_std(alt_std), .fmt_625(fmt_625),
    .vbi_pass(vbi_pass), .cc_field_en(cc_field_en), .luma_delay(luma_delay),
    .bright_sel(bright_sel), .contrast_sel(contrast_sel), .mono(mono),
    .pd_composite(pd_composite), .pd_svideo(pd_svideo), .gp_oe(gp_oe),
    .gp_out(gp_out), .aclk_sel(aclk_sel), .ext_cc(ext_cc), .cc_word(cc_word)
  );

  localparam logic [6:0] DEV = 7'h65;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [7];
  string      exp_tag [$];
  logic [7:0] exp_val [$];
  logic [7:0] obs_val;
  event       obs_ev;
  bit         done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected bus items as the design produces them
  initial begin
    forever begin
      @(obs_ev);
      if (exp_tag.size() == 0) chk("scoreboard underflow", obs_val, 8'hxx);
      else chk(exp_tag.pop_front(), obs_val, exp_val.pop_front());
    end
  end

  task automatic qt(); repeat (25) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; qt(); scl_m = 1'b1; qt(); sda_m = 1'b0; qt(); scl_m = 1'b0; qt();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qt(); scl_m = 1'b1; qt(); sda_m = 1'b1; qt(); qt();
  endtask

  // exp_ack 1 means the slave must pull SDA low in the ninth pulse
  task automatic send(string tag, logic [7:0] b, logic exp_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qt(); scl_m = 1'b1; qt(); qt(); scl_m = 1'b0; qt();
    end
    sda_m = 1'b1;
    exp_tag.push_back({tag, " ack"});
    exp_val.push_back({7'd0, ~exp_ack});
    qt(); scl_m = 1'b1; qt();
    obs_val = {7'd0, sda_bus};
    -> obs_ev;
    qt(); scl_m = 1'b0; qt();
  endtask

  task automatic recv(string tag, logic [7:0] exp_b, logic m_ack);
    logic [7:0] b;
    b = '0;
    exp_tag.push_back({tag, " read"});
    exp_val.push_back(exp_b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qt(); scl_m = 1'b1; qt(); b = {b[6:0], sda_bus}; qt(); scl_m = 1'b0; qt();
    end
    obs_val = b;
    -> obs_ev;
    sda_m = m_ack ? 1'b0 : 1'b1;
    qt(); scl_m = 1'b1; qt(); qt(); scl_m = 1'b0; qt();
    sda_m = 1'b1;
  endtask

  task automatic check_all(string ctx);
    chk({ctx, " R8 bw"},    chroma_bw,   mdl[0][7:6]);
    chk({ctx, " R8 comp"},  comp_mode,   mdl[0][5:4]);
    chk({ctx, " R8 misc"},  {hs_on_luma, subc_free, alt_std, fmt_625}, mdl[0][3:0]);
    chk({ctx, " R9 vbi"},   vbi_pass,    mdl[1][7]);
    chk({ctx, " R9 ccf"},   cc_field_en, mdl[1][6:5]);
    chk({ctx, " R9 ldly"},  luma_delay,  mdl[1][4]);
    chk({ctx, " R9 bri"},   bright_sel,  mdl[1][3:2]);
    chk({ctx, " R9 con"},   contrast_sel, mdl[1][1:0]);
    chk({ctx, " R10 pwr"},  {mono, pd_composite, pd_svideo}, mdl[2][7:5]);
    chk({ctx, " R10 oe"},   gp_oe,       {2{mdl[2][4]}});
    chk({ctx, " R10 gp"},   gp_out,      {mdl[2][3], mdl[2][2]});
    chk({ctx, " R10 aclk"}, aclk_sel,    mdl[2][1:0]);
    chk({ctx, " R11 xcc"},  ext_cc,      {mdl[3], mdl[4]});
    chk({ctx, " R11 cc"},   cc_word,     {mdl[5], mdl[6]});
  endtask

  initial begin
    for (int i = 0; i < 7; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R3 reset values
    check_all("R3 reset");
    chk("R3 sda released", sda_oe, 1'b0);

    // R2 single write: 0x30 to index 0 gives RGB component mode
    i2c_start();
    send("R2 dev", {DEV, 1'b0}, 1'b1);
    send("R2 idx", 8'h00, 1'b1);
    send("R2 data", 8'h30, 1'b1);
    i2c_stop();
    mdl[0] = 8'h30;
    chk("R8 comp rgb", comp_mode, 2'b11);
    check_all("R2 write");

    i2c_start();
    send("R8 dev", {DEV, 1'b0}, 1'b1);
    send("R8 idx", 8'h00, 1'b1);
    send("R8 data", 8'h8D, 1'b1);
    i2c_stop();
    mdl[0] = 8'h8D;
    check_all("R8 fields");

    // R4 burst over indices 1..6
    i2c_start();
    send("R4 dev", {DEV, 1'b0}, 1'b1);
    send("R4 idx", 8'h01, 1'b1);
    send("R4 d1", 8'hB6, 1'b1);
    send("R4 d2", 8'h5C, 1'b1);
    send("R4 d3", 8'h12, 1'b1);
    send("R4 d4", 8'h34, 1'b1);
    send("R4 d5", 8'h56, 1'b1);
    send("R4 d6", 8'h78, 1'b1);
    i2c_stop();
    mdl[1] = 8'hB6; mdl[2] = 8'h5C; mdl[3] = 8'h12;
    mdl[4] = 8'h34; mdl[5] = 8'h56; mdl[6] = 8'h78;
    check_all("R4 burst");
    chk("R10 oe on", gp_oe, 2'b11);

    // R10 enable off -> high impedance
    i2c_start();
    send("R10 dev", {DEV, 1'b0}, 1'b1);
    send("R10 idx", 8'h02, 1'b1);
    send("R10 data", 8'h08, 1'b1);
    i2c_stop();
    mdl[2] = 8'h08;
    chk("R10 oe off", gp_oe, 2'b00);
    chk("R10 gp vals", gp_out, 2'b10);

    // R1 foreign address
    i2c_start();
    send("R1 dev", {7'h66, 1'b0}, 1'b0);
    send("R1 idx", 8'h00, 1'b0);
    send("R1 data", 8'hFF, 1'b0);
    chk("R1 sda quiet", sda_oe, 1'b0);
    i2c_stop();
    check_all("R1 unchanged");

    // R5 burst crossing the end of the map
    i2c_start();
    send("R5 dev", {DEV, 1'b0}, 1'b1);
    send("R5 idx", 8'h06, 1'b1);
    send("R5 d6", 8'h9A, 1'b1);
    send("R5 d7", 8'hEE, 1'b1);
    i2c_stop();
    mdl[6] = 8'h9A;
    check_all("R5 discard");

    i2c_start();
    send("R5 rdev", {DEV, 1'b0}, 1'b1);
    send("R5 ridx", 8'h07, 1'b1);
    i2c_start();
    send("R5 rdevr", {DEV, 1'b1}, 1'b1);
    recv("R5 high idx", 8'h00, 1'b0);
    i2c_stop();

    // R6 read burst with repeated start
    i2c_start();
    send("R6 dev", {DEV, 1'b0}, 1'b1);
    send("R6 idx", 8'h03, 1'b1);
    i2c_start();
    send("R6 devr", {DEV, 1'b1}, 1'b1);
    recv("R6 b3", mdl[3], 1'b1);
    recv("R6 b4", mdl[4], 1'b1);
    recv("R6 b5", mdl[5], 1'b1);
    recv("R6 b6", mdl[6], 1'b0);
    qt();
    chk("R6 release after nack", sda_oe, 1'b0);
    i2c_stop();

    // R7 repeated start restarts the address phase
    i2c_start();
    send("R7 dev", {DEV, 1'b0}, 1'b1);
    send("R7 idx", 8'h01, 1'b1);
    i2c_start();
    send("R7 dev2", {DEV, 1'b0}, 1'b1);
    send("R7 idx2", 8'h04, 1'b1);
    send("R7 data", 8'h77, 1'b1);
    i2c_stop();
    mdl[4] = 8'h77;
    check_all("R7 restart");

    // R12 stop before any data byte
    i2c_start();
    send("R12 dev", {DEV, 1'b0}, 1'b1);
    send("R12 idx", 8'h00, 1'b1);
    i2c_stop();
    check_all("R12 no data");

    chk("scoreboard drained", exp_tag.size(), 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule